// File: doc/BRIEF.md
# Compute-and-restore word-line sequencer

This controller runs a single compute pass over a memory array that shares its row of sense amplifiers with a neighbouring array. Multi-row activation destroys the data in the target array, so the sequencer brackets it. First it copies the selected target row into the matching neighbour row, where the differential sense amplifier stores it inverted. Next it raises every target row named by the input vector and strobes the compute sense stage. Last it repeats the paired activation, and the inverted copy in the neighbour row rewrites the target row with its original contents.

A single-cycle `start` pulse begins a pass. On the cycle it is accepted, the row index and the input vector are captured. Each phase takes four cycles. In step 0 the bit lines are precharged. Step 1 raises the word lines. Steps 2 and 3 keep the word lines raised and enable the sense stage. Twelve cycles after acceptance a one-cycle `done` pulse follows, and after that the controller is idle and ready for another pass. The control pins are plain levels and pulses. The block has no streaming interface, so it has no back-pressure rules.

Top module: `cim_restore_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all word-line enables, `precharge`, `sa_en`, `csa_en`, `busy` and `done` are 0. Reset is asynchronous, so word lines drop as soon as reset goes low.
- R2: After a `start` is accepted in idle, the phases run in fixed order in consecutive cycles. Copy covers cycles 0 to 3 after acceptance, compute covers cycles 4 to 7 and recover covers cycles 8 to 11. Within each phase the step is (cycle mod 4).
- R3: `precharge` is 1 exactly in step 0 of each phase, and it is never 1 in a cycle where any word-line enable is 1.
- R4: In steps 1 to 3 of copy and recover, `wl_tgt` and `wl_nbr` are both the one-hot code of the captured row index (bit i set for row i). All other bits are 0.
- R5: In steps 1 to 3 of compute, `wl_tgt` equals the captured input vector (bit i raises row i) and `wl_nbr` is all zero.
- R6: `sa_en` is 1 in steps 2 and 3 of copy and recover only. `csa_en` is 1 in steps 2 and 3 of compute only. Each sense strobe therefore rises one cycle after its word lines rise.
- R7: `done` is 1 for exactly one cycle, cycle 12 after acceptance, with all word lines low. `busy` is 1 from cycle 0 through cycle 12 and 0 in idle.
- R8: A `start` that arrives while `busy` is 1 is ignored. The pass in progress keeps its captured row and vector, and no second pass follows it.
- R9: For an array model in which a paired activation with `sa_en` writes the complement of the intact side into the other side, and a target-only activation destroys the raised rows, the selected target row holds its original value after a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that requests a pass; taken only in idle |
| row_sel | input | ROW_W | Index of the target row to protect, captured at acceptance |
| in_rows | input | NUM_ROWS | Input vector of rows raised in compute, captured at acceptance |
| wl_tgt | output | NUM_ROWS | Word-line enables of the target array |
| wl_nbr | output | NUM_ROWS | Word-line enables of the neighbouring array |
| precharge | output | 1 | Bit-line precharge strobe |
| sa_en | output | 1 | Shared sense-amplifier enable |
| csa_en | output | 1 | Compute sense-amplifier enable |
| busy | output | 1 | High while a pass or its done cycle is in progress |
| done | output | 1 | One-cycle pulse after recover |

## Verification
Every row index is swept, and each one is paired with four input vectors. The empty vector shows whether compute raises anything beyond its vector. The all-ones vector shows whether the neighbour side stays low while every target row is high. A vector holding only the selected row shows whether compute can be told apart from copy by the neighbour lines and the sense strobe. A mixed vector that does not depend on the row is used in the run that also pulses `start` mid-pass, which shows whether the captured inputs can be overwritten. In every run, a behavioural array model in the bench is driven by the observed strobes, and it confirms that the selected row comes back unchanged. A separate reset issued in the middle of a pass must drop all word lines at once.

// File: rtl/cim_seq_pkg.sv
package cim_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_COPY = 3'd1,
    PH_COMP = 3'd2,
    PH_RECV = 3'd3,
    PH_DONE = 3'd4
  } phase_t;
endpackage

// File: rtl/cim_phase_ctrl.sv
module cim_phase_ctrl
  import cim_seq_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int SW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output phase_t        phase,
  output logic [SW-1:0] step,
  output logic          accept
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  assign accept = start && (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          step <= '0;
          if (start) phase <= PH_COPY;
        end
        PH_COPY, PH_COMP, PH_RECV: begin
          if (step == LAST) begin
            step <= '0;
            if (phase == PH_COPY)      phase <= PH_COMP;
            else if (phase == PH_COMP) phase <= PH_RECV;
            else                       phase <= PH_DONE;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: begin
          step  <= '0;
          phase <= PH_IDLE;
        end
      endcase
    end
  end

  AST_COMP_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COMP && $past(phase) != PH_COMP) |-> $past(phase) == PH_COPY); // R2

  AST_RECV_AFTER_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECV && $past(phase) != PH_RECV) |-> $past(phase) == PH_COMP); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> (phase == PH_IDLE)); // R7
endmodule

// File: rtl/cim_strobe_gen.sv
module cim_strobe_gen
  import cim_seq_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int SW = $clog2(STEPS)
) (
  input  phase_t        phase,
  input  logic [SW-1:0] step,
  output logic          wl_on,
  output logic          precharge,
  output logic          sa_en,
  output logic          csa_en,
  output logic          busy,
  output logic          done
);
  localparam logic [SW-1:0] WL_STEP    = SW'(1);
  localparam logic [SW-1:0] SENSE_STEP = SW'(2);

  logic active;
  logic sensing;

  always_comb begin
    active    = (phase == PH_COPY) || (phase == PH_COMP) || (phase == PH_RECV);
    sensing   = active && (step >= SENSE_STEP);
    precharge = active && (step < WL_STEP);
    wl_on     = active && (step >= WL_STEP);
    sa_en     = sensing && (phase != PH_COMP);
    csa_en    = sensing && (phase == PH_COMP);
    busy      = active || (phase == PH_DONE);
    done      = (phase == PH_DONE);
  end
endmodule

// File: rtl/cim_wl_drive.sv
module cim_wl_drive
  import cim_seq_pkg::*;
#(
  parameter int NUM_ROWS = 128,
  localparam int ROW_W = $clog2(NUM_ROWS)
) (
  input  phase_t              phase,
  input  logic                wl_on,
  input  logic [ROW_W-1:0]    row_q,
  input  logic [NUM_ROWS-1:0] vec_q,
  output logic [NUM_ROWS-1:0] wl_tgt,
  output logic [NUM_ROWS-1:0] wl_nbr
);
  logic multi;
  assign multi = (phase == PH_COMP);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic hit;
    assign hit       = (row_q == ROW_W'(i));
    assign wl_tgt[i] = wl_on && (multi ? vec_q[i] : hit);
    assign wl_nbr[i] = wl_on && !multi && hit;
  end
endmodule

// File: rtl/cim_restore_seq.sv
module cim_restore_seq
  import cim_seq_pkg::*;
#(
  parameter int NUM_ROWS = 128,
  parameter int STEPS    = 4,
  localparam int ROW_W = $clog2(NUM_ROWS),
  localparam int SW    = $clog2(STEPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ROW_W-1:0]    row_sel,
  input  logic [NUM_ROWS-1:0] in_rows,
  output logic [NUM_ROWS-1:0] wl_tgt,
  output logic [NUM_ROWS-1:0] wl_nbr,
  output logic                precharge,
  output logic                sa_en,
  output logic                csa_en,
  output logic                busy,
  output logic                done
);
  phase_t              phase;
  logic [SW-1:0]       step;
  logic                accept;
  logic                wl_on;
  logic [ROW_W-1:0]    row_q;
  logic [NUM_ROWS-1:0] vec_q;

  cim_phase_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phase(phase), .step(step), .accept(accept)
  );

  cim_strobe_gen #(.STEPS(STEPS)) u_strobe (
    .phase(phase), .step(step), .wl_on(wl_on), .precharge(precharge),
    .sa_en(sa_en), .csa_en(csa_en), .busy(busy), .done(done)
  );

  cim_wl_drive #(.NUM_ROWS(NUM_ROWS)) u_wl (
    .phase(phase), .wl_on(wl_on), .row_q(row_q), .vec_q(vec_q),
    .wl_tgt(wl_tgt), .wl_nbr(wl_nbr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      vec_q <= '0;
    end else if (accept) begin
      row_q <= row_sel;
      vec_q <= in_rows;
    end
  end

  AST_PRE_NO_WL: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |-> (wl_tgt == '0 && wl_nbr == '0)); // R3

  AST_PAIR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    sa_en |-> ($onehot0(wl_tgt) && wl_tgt != '0 && wl_nbr == wl_tgt)); // R4

  AST_COMP_NBR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    csa_en |-> (wl_nbr == '0)); // R5

  AST_SENSE_LAGS_WL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sa_en) || $rose(csa_en)) |-> ($past(busy) && $past(precharge) == 1'b0)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_BUSY_HOLDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($stable(row_q) && $stable(vec_q))); // R8
endmodule

// File: tb/test_cim_restore_seq.sv
module test_cim_restore_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 16;
  localparam int COLS  = 8;
  localparam int RW    = $clog2(ROWS);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [RW-1:0]   row_sel = '0;
  logic [ROWS-1:0] in_rows = '0;
  logic [ROWS-1:0] wl_tgt, wl_nbr;
  logic            precharge, sa_en, csa_en, busy, done;

  int total = 0;
  int fails = 0;

  logic [COLS-1:0] mem_t [ROWS];
  logic [COLS-1:0] mem_n [ROWS];
  logic [COLS-1:0] orig  [ROWS];
  bit              dirty [ROWS];

  cim_restore_seq #(.NUM_ROWS(ROWS)) i_cim_restore_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .row_sel(row_sel),
    .in_rows(in_rows), .wl_tgt(wl_tgt), .wl_nbr(wl_nbr),
    .precharge(precharge), .sa_en(sa_en), .csa_en(csa_en),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int r = 0; r < ROWS; r++) begin
      orig[r]  = COLS'(r * 29 + 7);
      mem_t[r] = orig[r];
      mem_n[r] = '0;
      dirty[r] = 1'b0;
    end
  endtask

  // behavioural array: paired sensing copies the intact side inverted, target-only activation destroys
  task automatic model_step();
    if (sa_en && wl_nbr != '0) begin
      for (int r = 0; r < ROWS; r++)
        if (wl_nbr[r] && wl_tgt[r]) begin
          if (dirty[r]) begin mem_t[r] = ~mem_n[r]; dirty[r] = 1'b0; end
          else mem_n[r] = ~mem_t[r];
        end
    end else if (wl_nbr == '0) begin
      for (int r = 0; r < ROWS; r++)
        if (wl_tgt[r]) begin mem_t[r] = COLS'(8'h5A ^ r); dirty[r] = 1'b1; end
    end
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " wl_tgt"}, 64'(wl_tgt), 64'd0);
    chk({tag, " wl_nbr"}, 64'(wl_nbr), 64'd0);
    chk({tag, " strobes"}, 64'({precharge, sa_en, csa_en, busy, done}), 64'd0);
  endtask

  task automatic check_cycle(input int k, input logic [RW-1:0] row, input logic [ROWS-1:0] vec);
    int ph, st;
    logic [ROWS-1:0] oh, et, en;
    logic ep, es, ec, eb, ed;
    oh = ROWS'(1) << row;
    ph = k / 4; st = k % 4;
    et = '0; en = '0; ep = 0; es = 0; ec = 0; eb = 0; ed = 0;
    if (k < 12) begin
      eb = 1; ep = (st == 0);
      if (st >= 1) begin
        et = (ph == 1) ? vec : oh;
        en = (ph == 1) ? '0 : oh;
      end
      es = (st >= 2) && (ph != 1);
      ec = (st >= 2) && (ph == 1);
    end else if (k == 12) begin
      eb = 1; ed = 1;
    end
    chk($sformatf("R2 R4 R5 wl_tgt k=%0d", k), 64'(wl_tgt), 64'(et));
    chk($sformatf("R4 R5 wl_nbr k=%0d", k), 64'(wl_nbr), 64'(en));
    chk($sformatf("R3 precharge k=%0d", k), 64'(precharge), 64'(ep));
    chk($sformatf("R6 sa_en/csa_en k=%0d", k), 64'({sa_en, csa_en}), 64'({es, ec}));
    chk($sformatf("R7 busy/done k=%0d", k), 64'({busy, done}), 64'({eb, ed}));
  endtask

  task automatic run_pass(input logic [RW-1:0] row, input logic [ROWS-1:0] vec, input bit poke);
    @(negedge clk);
    start = 1'b1; row_sel = row; in_rows = vec;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 16; k++) begin
      check_cycle(k, row, vec);
      model_step();
      if (poke && k == 5) begin
        start = 1'b1; row_sel = row + 1'b1; in_rows = ~vec;   // R8: must be ignored
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk($sformatf("R9 restored row %0d", row), 64'(mem_t[row]), 64'(orig[row]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    for (int r = 0; r < ROWS; r++) begin
      for (int p = 0; p < 4; p++) begin
        logic [ROWS-1:0] v;
        case (p)
          0: v = '0;
          1: v = '1;
          2: v = ROWS'(1) << r;
          default: v = ROWS'(16'hA5C3);
        endcase
        init_mem();
        run_pass(RW'(r), v, p == 3);
      end
    end

    // R1: reset mid-pass drops word lines immediately
    @(negedge clk);
    start = 1'b1; row_sel = RW'(3); in_rows = '1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 wl raised before reset", 64'(wl_tgt != '0), 64'd1);
    rst_n = 1'b0;
    #1;
    check_idle("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after mid reset");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule